// File: doc/BRIEF.md
# Programming Address and Row Latch Controller

This block sits on the memory side of a device programming port. The port decodes each serial command and passes it in as a single-cycle strobe with an opcode and a 14-bit payload. The controller keeps a 16-bit address pointer and a bank of row write latches. It stores the payloads in the latches, commits them to a program or configuration array a full row at a time, and returns array words for verify. It also performs row and bulk erases on small behavioural program, configuration and data arrays.

A write, row erase or bulk erase starts an internally timed operation. While that operation runs, the busy output is high and every incoming command is dropped. The row that a write commits is taken from the address held when the write begins. The latch used by a load is picked by the low address bits. As a result, a write never leaves its row, and loads that run past the latch count wrap onto earlier latches.

Top module: `prog_row_ctrl`

## Requirements
- R1: After reset the address is 0000h, busy is low and read data is 0. Every program and configuration word reads 3FFFh, every data byte reads FFh, and the two calibration words at 8009h and 800Ah hold the CAL_WORD0 and CAL_WORD1 parameters.
- R2: The opcode encoding is 0 none, 1 load-config, 2 load-program, 3 load-data, 4 read-program, 5 read-data, 6 increment, 7 reset-address, 8 begin-write, 9 row-erase and 10 bulk-erase. Reset-address forces the address to 0000h. Increment adds one and wraps from FFFFh to 0000h.
- R3: Load-config sets the address to 8000h and stores the payload in latch 0.
- R4: Load-program stores the payload in the latch indexed by address bits [2:0]. Loads that reach the same latch overwrite it, and the last one wins.
- R5: Begin-write, when the last load was a program or config load, writes latch i to address {addr[15:3], i} for all 8 latches. The address used is the one present at begin. After the write, every latch holds 3FFFh.
- R6: Begin-write with no load since the previous begin changes no memory and does not raise busy.
- R7: Begin-write after load-data writes payload bits [7:0] to data byte addr[3:0]. Read-data returns that byte zero-extended to 14 bits.
- R8: Row-erase sets to 3FFFh every program word whose address bits [15:5] match the current address. Words in other rows are kept.
- R9: Bulk-erase with the address in 0000h–7FFFh erases program memory and the configuration words at 8007h and 8008h. It also erases data memory when data_guard is 0. It keeps the user ID words.
- R10: Bulk-erase with the address in 8000h–8008h erases program memory and the configuration words and keeps data memory. At any other address it erases nothing. The calibration words are never erased.
- R11: Begin-write (when R5 or R7 applies), row-erase and bulk-erase make busy high for exactly BUSY_CYCLES cycles, starting the cycle after the command. Commands given while busy is high have no effect.
- R12: A read result appears on rd_data_o one cycle after the read command. Read-program at an address outside the program array and outside 8000h–800Fh returns 3FFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode (encoding in R2) |
| cmd_data | input | 14 | Command payload |
| data_guard | input | 1 | Data-protect setting; 1 keeps data memory on a low-region bulk erase |
| addr_o | output | 16 | Current address pointer |
| busy_o | output | 1 | Timed operation in progress |
| rd_data_o | output | 14 | Last read result |

## Verification
The bench builds the block with its defaults and sets BUSY_CYCLES to 12: 8 latches, a 64-word program array and 16-entry configuration and data arrays. With a 64-word array there are two 32-word erase rows, so a row erase can be shown to leave its neighbouring row intact. The 8-latch bank makes a load run of 8 words starting at 0002h wrap onto latches 0 and 1 and land in row 0008h–000Fh. The 12-cycle busy window is short enough to count exactly. Holding increment for 65536 cycles brings the FFFFh-to-0000h wrap inside the run.

// File: rtl/prog_row_pkg.sv
package prog_row_pkg;
  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_LOAD_CFG   = 4'd1,
    OP_LOAD_PROG  = 4'd2,
    OP_LOAD_DATA  = 4'd3,
    OP_READ_PROG  = 4'd4,
    OP_READ_DATA  = 4'd5,
    OP_INC_ADDR   = 4'd6,
    OP_RESET_ADDR = 4'd7,
    OP_BEGIN_PROG = 4'd8,
    OP_ERASE_ROW  = 4'd9,
    OP_ERASE_BULK = 4'd10
  } prog_op_e;

  // Word offsets inside the configuration region
  localparam int CFG_WORD_A = 7;
  localparam int CFG_WORD_B = 8;
  localparam int CAL_WORD_A = 9;
  localparam int CAL_WORD_B = 10;
endpackage

// File: rtl/prog_addr_ctr.sv
module prog_addr_ctr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              set_cfg,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  always_comb begin
    addr_d = addr;
    if (clr)          addr_d = '0;
    else if (set_cfg) addr_d = {1'b1, {(ADDR_W-1){1'b0}}};
    else if (inc)     addr_d = addr + 1'b1;
  end

  assign addr_en = clr | set_cfg | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_d;
  end
endmodule

// File: rtl/prog_latch_bank.sv
module prog_latch_bank #(
  parameter int DATA_W     = 14,
  parameter int LATCH_BITS = 3,
  localparam int NLAT      = 1 << LATCH_BITS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [LATCH_BITS-1:0]             widx,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              clr,
  output logic [NLAT-1:0][DATA_W-1:0]       lat
);
  logic [NLAT-1:0][DATA_W-1:0] lat_d;
  logic                        lat_en;

  always_comb begin
    lat_d = lat;
    if (clr)     lat_d = '1;
    else if (we) lat_d[widx] = wdata;
  end

  assign lat_en = clr | we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat <= '1;
    else if (lat_en) lat <= lat_d;
  end
endmodule

// File: rtl/prog_busy_timer.sv
module prog_busy_timer #(
  parameter int CYCLES = 12,
  localparam int CW    = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (start)            cnt_d = CW'(CYCLES);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  assign cnt_en = start | (cnt_q != '0);
  assign busy   = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/prog_mem_arrays.sv
module prog_mem_arrays
  import prog_row_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 14,
  parameter int LATCH_BITS = 3,
  parameter int PROG_BITS  = 6,
  parameter int CFG_BITS   = 4,
  parameter int DMEM_BITS  = 4,
  parameter int ROW_BITS   = 5,
  parameter logic [DATA_W-1:0] CAL_WORD0 = '0,
  parameter logic [DATA_W-1:0] CAL_WORD1 = '0,
  localparam int NLAT  = 1 << LATCH_BITS,
  localparam int NPROG = 1 << PROG_BITS,
  localparam int NCFG  = 1 << CFG_BITS,
  localparam int NDMEM = 1 << DMEM_BITS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NLAT-1:0][DATA_W-1:0] lat,
  input  logic                        row_we,
  input  logic                        byte_we,
  input  logic [7:0]                  byte_val,
  input  logic                        erase_row,
  input  logic                        erase_bulk,
  input  logic                        keep_data,
  output logic [DATA_W-1:0]           rd_word,
  output logic [7:0]                  rd_byte
);
  logic [NPROG-1:0][DATA_W-1:0] prog_q, prog_d;
  logic [NCFG-1:0][DATA_W-1:0]  cfg_q, cfg_d;
  logic [NDMEM-1:0][7:0]        dm_q, dm_d;
  logic                         in_prog, in_cfg, bulk_lo, bulk_hi, mem_en;
  logic [ADDR_W-1:0]            tgt;

  assign in_prog = (addr[ADDR_W-1:PROG_BITS] == '0);
  assign in_cfg  = addr[ADDR_W-1] && (addr[ADDR_W-2:CFG_BITS] == '0);
  assign bulk_lo = !addr[ADDR_W-1];
  assign bulk_hi = addr[ADDR_W-1] && (addr[ADDR_W-2:0] <= (ADDR_W-1)'(CFG_WORD_B));

  always_comb begin
    prog_d = prog_q;
    cfg_d  = cfg_q;
    dm_d   = dm_q;
    tgt    = addr;
    if (row_we) begin
      for (int i = 0; i < NLAT; i++) begin
        tgt = {addr[ADDR_W-1:LATCH_BITS], LATCH_BITS'(i)};
        if (in_prog) prog_d[tgt[PROG_BITS-1:0]] = lat[i];
        if (in_cfg)  cfg_d[tgt[CFG_BITS-1:0]]   = lat[i];
      end
    end
    if (byte_we) dm_d[addr[DMEM_BITS-1:0]] = byte_val;
    if (erase_row) begin
      for (int j = 0; j < NPROG; j++) begin
        if ((ADDR_W'(j) >> ROW_BITS) == (addr >> ROW_BITS)) prog_d[j] = '1;
      end
    end
    if (erase_bulk && (bulk_lo || bulk_hi)) begin
      prog_d             = '1;
      cfg_d[CFG_WORD_A]  = '1;
      cfg_d[CFG_WORD_B]  = '1;
      if (bulk_lo && !keep_data) dm_d = '1;
    end
  end

  assign mem_en = row_we | byte_we | erase_row | erase_bulk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q            <= '1;
      cfg_q             <= '1;
      cfg_q[CAL_WORD_A] <= CAL_WORD0;
      cfg_q[CAL_WORD_B] <= CAL_WORD1;
      dm_q              <= '1;
    end else if (mem_en) begin
      prog_q <= prog_d;
      cfg_q  <= cfg_d;
      dm_q   <= dm_d;
    end
  end

  assign rd_word = in_prog ? prog_q[addr[PROG_BITS-1:0]] :
                   in_cfg  ? cfg_q[addr[CFG_BITS-1:0]]   : '1;
  assign rd_byte = dm_q[addr[DMEM_BITS-1:0]];
endmodule

// File: rtl/prog_row_ctrl.sv
module prog_row_ctrl
  import prog_row_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 14,
  parameter int LATCH_BITS  = 3,
  parameter int PROG_BITS   = 6,
  parameter int CFG_BITS    = 4,
  parameter int DMEM_BITS   = 4,
  parameter int ROW_BITS    = 5,
  parameter int BUSY_CYCLES = 12,
  parameter logic [DATA_W-1:0] CAL_WORD0 = 14'h2A5C,
  parameter logic [DATA_W-1:0] CAL_WORD1 = 14'h1C3E,
  localparam int NLAT = 1 << LATCH_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              data_guard,
  output logic [ADDR_W-1:0] addr_o,
  output logic              busy_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  prog_op_e op;
  logic     acc;
  assign op  = prog_op_e'(cmd_op);
  assign acc = cmd_valid && !busy_o;

  // Pending-load tracking
  logic       pend_q, pend_d, pdm_q, pdm_d;
  logic [7:0] byte_q, byte_d;
  logic       go_write, row_we, byte_we, start_busy;

  always_comb begin
    pend_d = pend_q;
    pdm_d  = pdm_q;
    byte_d = byte_q;
    if (acc) begin
      case (op)
        OP_LOAD_CFG, OP_LOAD_PROG: begin pend_d = 1'b1; pdm_d = 1'b0; end
        OP_LOAD_DATA: begin pend_d = 1'b1; pdm_d = 1'b1; byte_d = cmd_data[7:0]; end
        OP_BEGIN_PROG: pend_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      pend_q <= 1'b0;
      pdm_q  <= 1'b0;
      byte_q <= '0;
    end else if (acc) begin
      pend_q <= pend_d;
      pdm_q  <= pdm_d;
      byte_q <= byte_d;
    end
  end

  assign go_write   = acc && (op == OP_BEGIN_PROG) && pend_q;
  assign row_we     = go_write && !pdm_q;
  assign byte_we    = go_write && pdm_q;
  assign start_busy = go_write || (acc && (op == OP_ERASE_ROW || op == OP_ERASE_BULK));

  prog_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clr     (acc && op == OP_RESET_ADDR),
    .set_cfg (acc && op == OP_LOAD_CFG),
    .inc     (acc && op == OP_INC_ADDR),
    .addr    (addr_o)
  );

  logic [NLAT-1:0][DATA_W-1:0] lat;
  logic [LATCH_BITS-1:0]       widx;
  assign widx = (op == OP_LOAD_CFG) ? '0 : addr_o[LATCH_BITS-1:0];

  prog_latch_bank #(.DATA_W(DATA_W), .LATCH_BITS(LATCH_BITS)) u_lat (
    .clk   (clk),
    .rst_n (rst_n_i),
    .we    (acc && (op == OP_LOAD_PROG || op == OP_LOAD_CFG)),
    .widx  (widx),
    .wdata (cmd_data),
    .clr   (row_we),
    .lat   (lat)
  );

  prog_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst_n (rst_n_i),
    .start (start_busy),
    .busy  (busy_o)
  );

  logic [DATA_W-1:0] rd_word, rd_d;
  logic [7:0]        rd_byte;
  logic              rd_en;

  prog_mem_arrays #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATCH_BITS(LATCH_BITS),
    .PROG_BITS(PROG_BITS), .CFG_BITS(CFG_BITS), .DMEM_BITS(DMEM_BITS),
    .ROW_BITS(ROW_BITS), .CAL_WORD0(CAL_WORD0), .CAL_WORD1(CAL_WORD1)
  ) u_mem (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .addr       (addr_o),
    .lat        (lat),
    .row_we     (row_we),
    .byte_we    (byte_we),
    .byte_val   (byte_q),
    .erase_row  (acc && op == OP_ERASE_ROW),
    .erase_bulk (acc && op == OP_ERASE_BULK),
    .keep_data  (data_guard),
    .rd_word    (rd_word),
    .rd_byte    (rd_byte)
  );

  assign rd_en = acc && (op == OP_READ_PROG || op == OP_READ_DATA);
  assign rd_d  = (op == OP_READ_DATA) ? {{(DATA_W-8){1'b0}}, rd_byte} : rd_word;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)   rd_data_o <= '0;
    else if (rd_en) rd_data_o <= rd_d;
  end
endmodule

// File: rtl/prog_row_ctrl_chk.sv
module prog_row_ctrl_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 14,
  parameter int CFG_BITS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic [ADDR_W-1:0] addr_o,
  input logic              busy_o,
  input logic [DATA_W-1:0] rd_data_o
);
  logic acc;
  assign acc = cmd_valid && !busy_o;

  assert_rst_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd7 |=> addr_o == '0);

  assert_inc_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd6 |=> addr_o == ADDR_W'($past(addr_o) + 1'b1));

  assert_cfg_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd1 |=> addr_o == {1'b1, {(ADDR_W-1){1'b0}}});

  assert_erase_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (cmd_op == 4'd9 || cmd_op == 4'd10) |=> busy_o);

  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy_o |=> $stable(addr_o) && $stable(rd_data_o));

  assert_unmapped_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_op == 4'd4 && addr_o[ADDR_W-1] && addr_o[ADDR_W-2:CFG_BITS] != '0
    |=> rd_data_o == '1);
endmodule

bind prog_row_ctrl prog_row_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_BITS(CFG_BITS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_i),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .addr_o    (addr_o),
  .busy_o    (busy_o),
  .rd_data_o (rd_data_o)
);

// File: tb/prog_row_ctrl_bench.sv
module prog_row_ctrl_bench;
  localparam int BUSY = 12;
  localparam int CAL0 = 'h2A5C;
  localparam int CAL1 = 'h1C3E;
  localparam int ONES = 'h3FFF;

  logic        clk = 1'b0;
  logic        rst_n, cmd_valid, data_guard;
  logic [3:0]  cmd_op;
  logic [13:0] cmd_data;
  logic [15:0] addr_o;
  logic        busy_o;
  logic [13:0] rd_data_o;

  always #4 clk = ~clk;

  prog_row_ctrl #(.BUSY_CYCLES(BUSY)) u_prog_row_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .data_guard(data_guard), .addr_o(addr_o),
    .busy_o(busy_o), .rd_data_o(rd_data_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_addr, m_cnt, m_db, m_rd;
  int m_lat[8];
  int m_prog[64];
  int m_cfg[16];
  int m_dm[16];
  bit m_pend, m_pdm, m_live = 1'b0;

  function automatic int m_read(int a);
    if (a < 64) return m_prog[a];
    if (a >= 'h8000 && a < 'h8010) return m_cfg[a - 'h8000];
    return ONES;
  endfunction

  task automatic m_reset();
    m_addr = 0; m_cnt = 0; m_db = 0; m_rd = 0; m_pend = 0; m_pdm = 0;
    foreach (m_lat[k]) m_lat[k] = ONES;
    foreach (m_prog[k]) m_prog[k] = ONES;
    foreach (m_cfg[k]) m_cfg[k] = ONES;
    m_cfg[9] = CAL0; m_cfg[10] = CAL1;
    foreach (m_dm[k]) m_dm[k] = 255;
  endtask

  always @(posedge clk) begin
    bit acc;
    int base, a;
    if (m_live) begin
      acc = cmd_valid && (m_cnt == 0);
      if (m_cnt > 0) m_cnt--;
      if (acc) begin
        case (int'(cmd_op))
          1: begin m_addr = 'h8000; m_lat[0] = cmd_data; m_pend = 1; m_pdm = 0; end
          2: begin m_lat[m_addr % 8] = cmd_data; m_pend = 1; m_pdm = 0; end
          3: begin m_db = cmd_data & 255; m_pend = 1; m_pdm = 1; end
          4: m_rd = m_read(m_addr);
          5: m_rd = m_dm[m_addr % 16];
          6: m_addr = (m_addr + 1) % 65536;
          7: m_addr = 0;
          8: if (m_pend) begin
               if (m_pdm) m_dm[m_addr % 16] = m_db;
               else begin
                 base = m_addr - (m_addr % 8);
                 for (int k = 0; k < 8; k++) begin
                   a = base + k;
                   if (a < 64) m_prog[a] = m_lat[k];
                   else if (a >= 'h8000 && a < 'h8010) m_cfg[a - 'h8000] = m_lat[k];
                 end
                 foreach (m_lat[k]) m_lat[k] = ONES;
               end
               m_pend = 0;
               m_cnt = BUSY;
             end
          9: begin
               for (int k = 0; k < 64; k++) if (k / 32 == m_addr / 32) m_prog[k] = ONES;
               m_cnt = BUSY;
             end
          10: begin
               if (m_addr <= 'h8008) begin
                 foreach (m_prog[k]) m_prog[k] = ONES;
                 m_cfg[7] = ONES; m_cfg[8] = ONES;
                 if (m_addr < 'h8000 && !data_guard) foreach (m_dm[k]) m_dm[k] = 255;
               end
               m_cnt = BUSY;
             end
          default: ;
        endcase
      end
    end
  end

  // Compare against the model on every cycle
  always @(negedge clk) begin
    if (m_live) begin
      chk(int'(addr_o) == m_addr, "R2 address track", addr_o, m_addr);
      chk(busy_o == (m_cnt != 0), "R11 busy track", busy_o, m_cnt != 0);
      chk(int'(rd_data_o) == m_rd, "R12 read data track", rd_data_o, m_rd);
    end
  end

  task automatic cmd(input int op, input int d = 0);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_data = 14'(d);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle_wait();
    while (busy_o) @(negedge clk);
  endtask

  task automatic go(input int a);
    cmd(7);
    repeat (a) cmd(6);
  endtask

  task automatic go_cfg(input int off);
    cmd(1, ONES);
    repeat (off) cmd(6);
  endtask

  task automatic rd_prog(input int exp, input string tag);
    cmd(4);
    chk(int'(rd_data_o) == exp, tag, rd_data_o, exp);
  endtask

  task automatic rd_data(input int exp, input string tag);
    cmd(5);
    chk(int'(rd_data_o) == exp, tag, rd_data_o, exp);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = '0; cmd_data = '0; data_guard = 1'b1;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_live = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(addr_o == 16'h0, "R1 reset address", addr_o, 0);
    chk(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
    chk(rd_data_o == 14'h0, "R1 reset read data", rd_data_o, 0);
    rd_prog(ONES, "R1 erased program word");
    rd_data(8'hFF, "R1 erased data byte");
    go_cfg(9);
    rd_prog(CAL0, "R1 calibration word 0");
    cmd(6);
    rd_prog(CAL1, "R1 calibration word 1");

    // R2 reset-address and increment
    cmd(7);
    chk(addr_o == 16'h0, "R2 reset address", addr_o, 0);
    cmd(6); cmd(6);
    chk(addr_o == 16'h2, "R2 increment", addr_o, 2);

    // R4/R5 loads wrap on latches; row chosen at begin
    for (int k = 0; k < 8; k++) begin
      cmd(2, 'h100 + k);
      cmd(6);
    end
    chk(addr_o == 16'hA, "R5 address at begin", addr_o, 'hA);
    cmd(8);
    idle_wait();
    go(8);    rd_prog('h106, "R5 row write word 08h");
    go(15);   rd_prog('h105, "R5 row write word 0Fh");
    go(2);    rd_prog(ONES, "R5 word outside row untouched");

    cmd(7);
    cmd(2, 'h111);
    cmd(2, 'h222);
    cmd(8);
    idle_wait();
    rd_prog('h222, "R4 last load wins");
    cmd(6);
    rd_prog(ONES, "R5 latches reset after write");

    // R6 begin without load
    cmd(7);
    cmd(8);
    chk(busy_o == 1'b0, "R6 no busy without load", busy_o, 0);
    rd_prog('h222, "R6 memory unchanged");

    // R11 busy length and ignored command
    cmd(7);
    cmd(2, 5);
    cmd(8);
    chk(busy_o == 1'b1, "R11 busy after begin", busy_o, 1);
    cmd(6);
    chk(addr_o == 16'h0, "R11 command ignored while busy", addr_o, 0);
    n = 0;
    while (busy_o) begin n++; @(negedge clk); end
    chk(n == BUSY - 1, "R11 busy length", n, BUSY - 1);

    // R7 data memory write
    go(3);
    cmd(3, 'h2A5);
    cmd(8);
    idle_wait();
    rd_data('h0A5, "R7 data byte written");

    // R8 row erase
    go(32);
    cmd(2, 'h0AB);
    cmd(8);
    idle_wait();
    go(5);
    cmd(9);
    chk(busy_o == 1'b1, "R11 busy after row erase", busy_o, 1);
    idle_wait();
    go(8);  rd_prog(ONES, "R8 row word erased");
    go(32); rd_prog('h0AB, "R8 other row kept");

    // R3 / R9 configuration write then low-region bulk erase
    cmd(1, 'h155);
    chk(addr_o == 16'h8000, "R3 load-config address", addr_o, 'h8000);
    repeat (7) cmd(6);
    cmd(2, 'h1234);
    cmd(8);
    idle_wait();
    rd_prog('h1234, "R9 config word written");
    data_guard = 1'b1;
    cmd(7);
    cmd(10);
    idle_wait();
    go(32); rd_prog(ONES, "R9 program erased");
    go_cfg(0);
    rd_prog('h155, "R3 latch 0 written at 8000h, user ID kept");
    repeat (7) cmd(6);
    rd_prog(ONES, "R9 config word erased");
    go(3);  rd_data('h0A5, "R9 guarded data kept");
    data_guard = 1'b0;
    cmd(7);
    cmd(10);
    idle_wait();
    go(3);  rd_data('h0FF, "R9 unguarded data erased");

    // R10 high-region bulk erase
    go(3);
    cmd(3, 'h5A);
    cmd(8);
    idle_wait();
    cmd(7);
    cmd(2, 'h77);
    cmd(8);
    idle_wait();
    go_cfg(8);
    cmd(10);
    idle_wait();
    go(0);  rd_prog(ONES, "R10 program erased from 8008h");
    go(3);  rd_data('h05A, "R10 data kept");
    go_cfg(9);
    rd_prog(CAL0, "R10 calibration kept");
    cmd(7);
    cmd(2, 'h77);
    cmd(8);
    idle_wait();
    go_cfg(9);
    cmd(10);
    idle_wait();
    go(0);  rd_prog('h77, "R10 no erase above 8008h");

    // R12 unmapped read
    go_cfg(16);
    rd_prog(ONES, "R12 unmapped address");

    // R2 wrap at 16 bits
    cmd(7);
    cmd_valid = 1'b1; cmd_op = 4'd6; cmd_data = '0;
    repeat (65535) @(negedge clk);
    chk(addr_o == 16'hFFFF, "R2 address reaches FFFFh", addr_o, 'hFFFF);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(addr_o == 16'h0, "R2 address wraps to 0000h", addr_o, 0);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule